// File: doc/BRIEF.md
# Registered Bidirectional Bus Transceiver

This block joins two parallel ports, called A and B, through a pair of independent storage registers, one per direction. Each register has its own load strobe. It captures the data at its source port whenever that strobe rises, whatever the output controls are doing at that moment. For each direction a select input picks what is presented to the far port: the live value from the opposite port (transparent), or the contents of that direction's register (stored).

An active-low output enable and a direction input choose which port, if any, is driven. A build-time parameter makes both data paths true or bitwise inverting. Each bidirectional port is split into an input vector, an output value vector and an output-enable vector, so that pads or a tristate wrapper can be attached outside the block.

The whole block runs on one system clock. The two load strobes are sampled on that clock, and a load happens on the first cycle in which a strobe is seen high after being low. The port outputs are combinational from the controls, the port inputs and the register contents. The drive decode is a three-way port mode: ISOLATE (neither port driven), DRIVE_B (B driven from the A side), and DRIVE_A (A driven from the B side). The mode changes at once when the enable or direction input changes, with no clocked transition.

Top module: `xcvr_reg_bus`

## Requirements
- R1: A synchronous active-high reset clears both registers to zero, so stored-mode outputs read all zeros (all ones when inverting) right after reset.
- R2: The A-to-B register loads `a_in` on the clock edge where `strobe_ab` is first seen high after being low; holding the strobe high causes no further load.
- R3: The B-to-A register loads `b_in` on the clock edge where `strobe_ba` is first seen high after being low; holding the strobe high causes no further load.
- R4: Register loads are never gated by `oe_n` or `dir`. Both registers can load while neither port is driven, and a register can load while its source port is the one being driven.
- R5: With `oe_n` = 1 (mode ISOLATE), `a_oe` and `b_oe` are all zeros.
- R6: With `oe_n` = 0, `dir` = 1 selects DRIVE_B (`b_oe` all ones, `a_oe` all zeros) and `dir` = 0 selects DRIVE_A (`a_oe` all ones, `b_oe` all zeros). Each enable vector is always all ones or all zeros.
- R7: `sel_ab` = 0 gives `b_out` the live `a_in` in the same cycle, and a load strobe edge at that time also stores that value. `sel_ab` = 1 gives `b_out` the A-to-B register.
- R8: `sel_ba` = 0 gives `a_out` the live `b_in`; `sel_ba` = 1 gives `a_out` the B-to-A register.
- R9: With `INVERT` = 1, `a_out` and `b_out` are the bitwise complement of the selected source. The registers hold true data, and the enables are unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| oe_n | input | 1 | Output enable, active low |
| dir | input | 1 | 1: drive B, 0: drive A |
| strobe_ab | input | 1 | Load strobe for the A-to-B register |
| strobe_ba | input | 1 | Load strobe for the B-to-A register |
| sel_ab | input | 1 | 0: live A to B, 1: stored A-to-B register to B |
| sel_ba | input | 1 | 0: live B to A, 1: stored B-to-A register to A |
| a_in | input | WIDTH | Value seen on port A |
| a_out | output | WIDTH | Value to drive on port A |
| a_oe | output | WIDTH | Per-bit drive enable for port A |
| b_in | input | WIDTH | Value seen on port B |
| b_out | output | WIDTH | Value to drive on port B |
| b_oe | output | WIDTH | Per-bit drive enable for port B |

## Verification
A wrong register value is invisible in transparent mode. It shows only once the matching select is high, and then it appears on the far port's output in that same cycle, so the bench puts each direction into stored mode right after every load and every reset. A wrong strobe-edge state shows up one cycle after the strobe changes, as either a missing or an extra load. The bench holds a strobe high across several vectors with new data to expose a level-triggered load. Both the true and the inverting variants are driven from the same stimulus and compared on every vector.

// File: rtl/xcvr_pkg.sv
package xcvr_pkg;

    typedef enum logic [1:0] {
        MODE_ISOLATE = 2'd0,
        MODE_DRIVE_B = 2'd1,
        MODE_DRIVE_A = 2'd2
    } port_mode_e;

endpackage

// File: rtl/xcvr_strobe_edge.sv
module xcvr_strobe_edge (
    input  logic clk,
    input  logic rst,
    input  logic strobe,
    output logic fire
);
    logic prev_q;

    // Held high in reset so a strobe already high at release is not an edge.
    always_ff @(posedge clk) begin
        if (rst) prev_q <= 1'b1;
        else     prev_q <= strobe;
    end

    assign fire = strobe & ~prev_q & ~rst;
endmodule

// File: rtl/xcvr_store_reg.sv
module xcvr_store_reg #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    always_ff @(posedge clk) begin
        if (rst)       q <= '0;
        else if (load) q <= d;
    end
endmodule

// File: rtl/xcvr_path_mux.sv
module xcvr_path_mux #(
    parameter int WIDTH  = 8,
    parameter bit INVERT = 1'b0
) (
    input  logic             use_stored,
    input  logic [WIDTH-1:0] live,
    input  logic [WIDTH-1:0] stored,
    output logic [WIDTH-1:0] drive
);
    logic [WIDTH-1:0] pick;

    assign pick = use_stored ? stored : live;

    generate
        if (INVERT) begin : g_inv
            assign drive = ~pick;
        end else begin : g_true
            assign drive = pick;
        end
    endgenerate
endmodule

// File: rtl/xcvr_reg_bus.sv
module xcvr_reg_bus
    import xcvr_pkg::*;
#(
    parameter int WIDTH  = 8,
    parameter bit INVERT = 1'b0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             oe_n,
    input  logic             dir,
    input  logic             strobe_ab,
    input  logic             strobe_ba,
    input  logic             sel_ab,
    input  logic             sel_ba,
    input  logic [WIDTH-1:0] a_in,
    output logic [WIDTH-1:0] a_out,
    output logic [WIDTH-1:0] a_oe,
    input  logic [WIDTH-1:0] b_in,
    output logic [WIDTH-1:0] b_out,
    output logic [WIDTH-1:0] b_oe
);
    localparam logic [WIDTH-1:0] ALL_ON = {WIDTH{1'b1}};

    logic             load_ab, load_ba;
    logic [WIDTH-1:0] reg_ab, reg_ba;
    port_mode_e       mode;

    xcvr_strobe_edge u_edge_ab (.clk(clk), .rst(rst), .strobe(strobe_ab), .fire(load_ab));
    xcvr_strobe_edge u_edge_ba (.clk(clk), .rst(rst), .strobe(strobe_ba), .fire(load_ba));

    xcvr_store_reg #(.WIDTH(WIDTH)) u_reg_ab (
        .clk(clk), .rst(rst), .load(load_ab), .d(a_in), .q(reg_ab));
    xcvr_store_reg #(.WIDTH(WIDTH)) u_reg_ba (
        .clk(clk), .rst(rst), .load(load_ba), .d(b_in), .q(reg_ba));

    xcvr_path_mux #(.WIDTH(WIDTH), .INVERT(INVERT)) u_mux_b (
        .use_stored(sel_ab), .live(a_in), .stored(reg_ab), .drive(b_out));
    xcvr_path_mux #(.WIDTH(WIDTH), .INVERT(INVERT)) u_mux_a (
        .use_stored(sel_ba), .live(b_in), .stored(reg_ba), .drive(a_out));

    // Port mode decode
    always_comb begin
        unique case ({oe_n, dir})
            2'b01:   mode = MODE_DRIVE_B;
            2'b00:   mode = MODE_DRIVE_A;
            default: mode = MODE_ISOLATE;
        endcase
    end

    // Enables from mode
    always_comb begin
        a_oe = '0;
        b_oe = '0;
        unique case (mode)
            MODE_DRIVE_A: a_oe = ALL_ON;
            MODE_DRIVE_B: b_oe = ALL_ON;
            default: ;
        endcase
    end
endmodule

// File: rtl/xcvr_reg_bus_chk.sv
module xcvr_reg_bus_chk #(
    parameter int WIDTH  = 8,
    parameter bit INVERT = 1'b0
) (
    input logic             clk,
    input logic             rst,
    input logic             oe_n,
    input logic             dir,
    input logic             strobe_ab,
    input logic             strobe_ba,
    input logic             sel_ab,
    input logic             sel_ba,
    input logic [WIDTH-1:0] a_in,
    input logic [WIDTH-1:0] a_out,
    input logic [WIDTH-1:0] a_oe,
    input logic [WIDTH-1:0] b_in,
    input logic [WIDTH-1:0] b_out,
    input logic [WIDTH-1:0] b_oe
);
    localparam logic [WIDTH-1:0] FLIP = INVERT ? {WIDTH{1'b1}} : {WIDTH{1'b0}};

    p_isolate_r5: assert property (@(posedge clk) disable iff (rst)
        oe_n |-> (a_oe == '0 && b_oe == '0));

    p_drive_b_r6: assert property (@(posedge clk) disable iff (rst)
        (!oe_n && dir) |-> (b_oe == {WIDTH{1'b1}} && a_oe == '0));

    p_drive_a_r6: assert property (@(posedge clk) disable iff (rst)
        (!oe_n && !dir) |-> (a_oe == {WIDTH{1'b1}} && b_oe == '0));

    p_live_b_r7: assert property (@(posedge clk) disable iff (rst)
        !sel_ab |-> (b_out == (a_in ^ FLIP)));

    p_live_a_r8: assert property (@(posedge clk) disable iff (rst)
        !sel_ba |-> (a_out == (b_in ^ FLIP)));

    p_load_ab_r2: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $rose(strobe_ab)) |=> (sel_ab -> (b_out == ($past(a_in) ^ FLIP))));

    p_load_ba_r3: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $rose(strobe_ba)) |=> (sel_ba -> (a_out == ($past(b_in) ^ FLIP))));

    p_clear_r1: assert property (@(posedge clk)
        rst |=> ((sel_ab -> b_out == FLIP) && (sel_ba -> a_out == FLIP)));
endmodule

bind xcvr_reg_bus xcvr_reg_bus_chk #(.WIDTH(WIDTH), .INVERT(INVERT)) u_chk (
    .clk(clk), .rst(rst), .oe_n(oe_n), .dir(dir),
    .strobe_ab(strobe_ab), .strobe_ba(strobe_ba),
    .sel_ab(sel_ab), .sel_ba(sel_ba),
    .a_in(a_in), .a_out(a_out), .a_oe(a_oe),
    .b_in(b_in), .b_out(b_out), .b_oe(b_oe));

// File: tb/test_xcvr_reg_bus.sv
module test_xcvr_reg_bus;
    localparam int W = 8;
    localparam int NV = 13;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic oe_n = 1'b1, dir = 1'b0, strobe_ab = 1'b0, strobe_ba = 1'b0;
    logic sel_ab = 1'b0, sel_ba = 1'b0;
    logic [W-1:0] a_in = '0, b_in = '0;
    logic [W-1:0] a_out, a_oe, b_out, b_oe;
    logic [W-1:0] ia_out, ia_oe, ib_out, ib_oe;

    int checks = 0;
    int fails = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    xcvr_reg_bus #(.WIDTH(W), .INVERT(1'b0)) i_xcvr_reg_bus (
        .clk(clk), .rst(rst), .oe_n(oe_n), .dir(dir),
        .strobe_ab(strobe_ab), .strobe_ba(strobe_ba), .sel_ab(sel_ab), .sel_ba(sel_ba),
        .a_in(a_in), .a_out(a_out), .a_oe(a_oe), .b_in(b_in), .b_out(b_out), .b_oe(b_oe));

    xcvr_reg_bus #(.WIDTH(W), .INVERT(1'b1)) i_xcvr_reg_bus_inv (
        .clk(clk), .rst(rst), .oe_n(oe_n), .dir(dir),
        .strobe_ab(strobe_ab), .strobe_ba(strobe_ba), .sel_ab(sel_ab), .sel_ba(sel_ba),
        .a_in(a_in), .a_out(ia_out), .a_oe(ia_oe), .b_in(b_in), .b_out(ib_out), .b_oe(ib_oe));

    // {oe_n,dir,sel_ab,sel_ba,strobe_ab,strobe_ba}, a_in, b_in, {a_oe,b_oe}, exp a_out, exp b_out
    localparam logic [39:0] TBL [NV] = '{
        {6'b100000, 8'h11, 8'h22, 2'b00, 8'h22, 8'h11}, // R5 isolation, live paths
        {6'b100011, 8'h5A, 8'hA5, 2'b00, 8'hA5, 8'h5A}, // R4 load both while isolated
        {6'b101100, 8'h00, 8'hFF, 2'b00, 8'hA5, 8'h5A}, // R4 R7 R8 stored values kept
        {6'b010100, 8'h3C, 8'hFF, 2'b01, 8'hA5, 8'h3C}, // R6 drive B, transparent
        {6'b010110, 8'hC3, 8'hFF, 2'b01, 8'hA5, 8'hC3}, // R7 transparent plus load
        {6'b011110, 8'h77, 8'hFF, 2'b01, 8'hA5, 8'hC3}, // R2 strobe held, no reload
        {6'b011100, 8'h77, 8'hFF, 2'b01, 8'hA5, 8'hC3}, // R2 strobe low
        {6'b011110, 8'h77, 8'hFF, 2'b01, 8'hA5, 8'h77}, // R2 new edge loads
        {6'b001000, 8'h77, 8'h96, 2'b10, 8'h96, 8'h77}, // R6 R8 drive A, live B
        {6'b001101, 8'h77, 8'h69, 2'b10, 8'h69, 8'h77}, // R3 edge loads B side
        {6'b001101, 8'h77, 8'h12, 2'b10, 8'h69, 8'h77}, // R3 held, no reload
        {6'b001100, 8'h77, 8'h34, 2'b10, 8'h69, 8'h77}, // R3 strobe low
        {6'b011101, 8'h77, 8'hE1, 2'b01, 8'hE1, 8'h77}  // R4 load B side while B driven
    };

    task automatic compare(input string req, input logic ea, input logic eb,
                           input logic [W-1:0] xa, input logic [W-1:0] xb);
        logic [4*W-1:0] act_t, exp_t, act_i, exp_i;
        act_t = {a_oe, b_oe, a_out, b_out};
        exp_t = {{W{ea}}, {W{eb}}, xa, xb};
        act_i = {ia_oe, ib_oe, ia_out, ib_out};
        exp_i = {{W{ea}}, {W{eb}}, ~xa, ~xb};
        checks++;
        if (act_t !== exp_t || act_i !== exp_i) begin
            fails++;
            $display("FAIL %s true act=%h exp=%h inv(R9) act=%h exp=%h",
                     req, act_t, exp_t, act_i, exp_i);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state seen through stored mode, isolated
        sel_ab = 1'b1; sel_ba = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        compare("R1", 1'b0, 1'b0, 8'h00, 8'h00);
        sel_ab = 1'b0; sel_ba = 1'b0;

        for (int i = 0; i < NV; i++) begin
            {oe_n, dir, sel_ab, sel_ba, strobe_ab, strobe_ba} = TBL[i][39:34];
            a_in = TBL[i][33:26];
            b_in = TBL[i][25:18];
            @(negedge clk);
            compare($sformatf("vector %0d", i), TBL[i][17], TBL[i][16],
                    TBL[i][15:8], TBL[i][7:0]);
        end

        // R1 mid-run reset clears both registers
        strobe_ab = 1'b0; strobe_ba = 1'b0;
        oe_n = 1'b1; sel_ab = 1'b1; sel_ba = 1'b1;
        rst = 1'b1;
        @(negedge clk);
        compare("R1 mid-run", 1'b0, 1'b0, 8'h00, 8'h00);
        rst = 1'b0;
        @(negedge clk);
        // R5 isolation with dir high still drives nothing
        dir = 1'b1;
        @(negedge clk);
        compare("R5", 1'b0, 1'b0, 8'h00, 8'h00);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        repeat (2000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end
endmodule